// File: doc/BRIEF.md
# Programmable Two-Input Logic Element Bank

This block is a bank of eight small logic cells that software turns into glue logic at run time. Each cell evaluates any Boolean function of two inputs through a 4-entry truth table. The result can go straight to the cell output or through a private flip-flop. Each of the two truth-table inputs comes from a multiplexer. One input chooses between the cell's own input pin and a fixed set of even-numbered neighbours. The other chooses between a fixed set of odd-numbered neighbours and a bit that software writes.

Software configures the bank through a flat register port. There is one control word per cell. Further registers hold the flip-flop clock enable, the software data bits, a live view of all cell outputs, and two event sources. Each event source watches one chosen cell output and emits a one-cycle strobe on its rising edge. One strobe serves as an interrupt request and the other as a conversion start. Two banks can be chained: the last cell's output leaves on `link_out`, and the neighbour bank's last cell enters on `link_in`.

Register map (word address on `reg_addr`): 0 to 7 are the cell control words; 8 is clock enable (bit 0); 9 is software data (bit k feeds cell k); 10 is the read-only output view; 11 is the interrupt source; 12 is the conversion source. Control word fields: bit 0 selects the registered output, bits 4:1 hold the truth table, bit 5 selects the pin for input A, bit 6 selects the odd neighbour for input B, bits 8:7 select the odd neighbour, and bits 10:9 select the even neighbour.

Top module: `lut_logic_bank`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero, `pin_out` is 0x00, and `irq_pulse` and `conv_pulse` are low.
- R2: A cell's function output equals truth-table bit {A,B} of control bits 4:1, where the index is 2*A+B. For example, table 0001 gives NOR and table 0010 gives B AND NOT A.
- R3: When control bit 5 is 1, input A is the cell's pin `pin_in[k]`. When it is 0, input A is the even feedback multiplexer output.
- R4: When control bit 6 is 1, input B is the odd feedback multiplexer output. When it is 0, input B is bit k of the software data register (address 9).
- R5: Control bits 10:9 drive the even feedback multiplexer. Codes 1, 2 and 3 pick the flip-flop values of cells 2, 4 and 6. Code 0 picks `link_in` for cell 0 and the flip-flop of cell 0 for every other cell.
- R6: Control bits 8:7 drive the odd feedback multiplexer. Codes 0, 1, 2 and 3 pick the flip-flop values of cells 1, 3, 5 and 7.
- R7: When control bit 0 is 1, the cell outputs its flip-flop; when it is 0, it outputs the function directly. A flip-flop loads the function on a clock edge only while bit 0 of address 8 is 1, and holds its value otherwise.
- R8: A control word reads back bits 10:0 as written and reads bits 31:11 as zero. Unmapped addresses read zero.
- R9: Address 10 reads all eight cell outputs in bits 7:0 at all times, with no software action needed.
- R10: `link_out` carries the output of cell 7.
- R11: Each event source register holds a cell index in bits 2:0 and an enable in bit 3. When it is enabled, a 0-to-1 change of the selected cell output raises its strobe for exactly the following cycle. A falling edge, or a disabled source, raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| pin_in | input | 8 | Dedicated input pin of each cell |
| pin_out | output | 8 | Output of each cell |
| link_in | input | 1 | Last-cell output of the neighbouring bank |
| link_out | output | 1 | Last-cell output of this bank |
| irq_pulse | output | 1 | Interrupt strobe from the first event source |
| conv_pulse | output | 1 | Conversion-start strobe from the second event source |

## Verification
The two event sources are independent edge detectors that can watch the same cell. The bench points both of them at cell 2 and raises that cell's pin. It then requires both strobes in the same cycle, and both low in the cycle after. It repeats the pin rise with one source disabled and requires a strobe from the enabled source only. A second coincidence concerns the clock-enable write and a flip-flop load in the same edge. The bench checks that the flip-flop holds through the edge that commits the enable, and only changes on the edge after.

// File: rtl/lut_bank_pkg.sv
// Package: shared constants and the per-cell control word layout.
// Assumes a bank of 2*2^FB_SEL_W cells with the even/odd neighbourhoods below.
package lut_bank_pkg;
    localparam int FB_SEL_W = 2;
    localparam int N_SEL    = 1 << FB_SEL_W;
    localparam int N_ELEM   = 2 * N_SEL;
    localparam int IDX_W    = $clog2(N_ELEM);
    localparam int TT_W     = 4;

    // Control word, MSB first: bits 10:9, 8:7, 6, 5, 4:1, 0.
    typedef struct packed {
        logic [FB_SEL_W-1:0] even_sel;
        logic [FB_SEL_W-1:0] odd_sel;
        logic                b_from_fb;
        logic                a_from_pin;
        logic [TT_W-1:0]     table_bits;
        logic                use_reg;
    } cell_cfg_t;

    localparam int CFG_W = $bits(cell_cfg_t);

    localparam int A_CLKEN = 8;
    localparam int A_SWDIN = 9;
    localparam int A_DOUT  = 10;
    localparam int A_IRQ   = 11;
    localparam int A_CONV  = 12;
endpackage

// File: rtl/lut_cell.sv
// Module: one logic cell. Picks inputs A and B, looks up the truth table and
// optionally registers the result. Assumes the feedback vectors are stable
// register outputs, so no combinational loop forms across cells.
module lut_cell
    import lut_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  cell_cfg_t         cfg,
    input  logic              pin,
    input  logic              sw_bit,
    input  logic [N_SEL-1:0]  fb_even,
    input  logic [N_SEL-1:0]  fb_odd,
    output logic              ff_q,
    output logic              y
);
    logic a_in;
    logic b_in;
    logic f_out;

    // Select the two truth-table inputs and evaluate the function.
    always_comb begin
        a_in  = cfg.a_from_pin ? pin : fb_even[cfg.even_sel];
        b_in  = cfg.b_from_fb  ? fb_odd[cfg.odd_sel] : sw_bit;
        f_out = cfg.table_bits[{a_in, b_in}];
    end

    // Cell flip-flop, loads only while the bank clock enable is set.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ff_q <= 1'b0;
        else if (clk_en)
            ff_q <= f_out;
    end

    assign y = cfg.use_reg ? ff_q : f_out;
endmodule

// File: rtl/rise_strobe.sv
// Module: watches one bit of a vector chosen by index and emits a one-cycle
// registered strobe the cycle after that bit goes from 0 to 1.
// Assumes the previous-value register tracks every bit every cycle.
module rise_strobe #(
    parameter int W     = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     sig,
    input  logic [IDX_W-1:0] idx,
    input  logic             en,
    output logic             strobe
);
    logic [W-1:0] prev_q;

    // Remember last cycle's values and flag a rise on the chosen bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            strobe <= 1'b0;
        end else begin
            prev_q <= sig;
            strobe <= en && sig[idx] && !prev_q[idx];
        end
    end
endmodule

// File: rtl/lut_logic_bank.sv
// Module: bank of eight programmable two-input logic cells with a register
// port, feedback neighbourhoods, a chain link and two rising-edge strobes.
// Assumes one register access per cycle; reads are combinational.
module lut_logic_bank
    import lut_bank_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [N_ELEM-1:0] pin_in,
    output logic [N_ELEM-1:0] pin_out,
    input  logic              link_in,
    output logic              link_out,
    output logic              irq_pulse,
    output logic              conv_pulse
);
    localparam int SRC_W = IDX_W + 1;

    cell_cfg_t           cfg_q [N_ELEM];
    logic                clk_en_q;
    logic [N_ELEM-1:0]   sw_din_q;
    logic [SRC_W-1:0]    irq_src_q;
    logic [SRC_W-1:0]    conv_src_q;
    logic [N_ELEM-1:0]   ff_q;
    logic [N_ELEM-1:0]   cell_y;
    logic [N_SEL-1:0]    fb_odd;

    // Register file writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ELEM; i++) cfg_q[i] <= '0;
            clk_en_q   <= 1'b0;
            sw_din_q   <= '0;
            irq_src_q  <= '0;
            conv_src_q <= '0;
        end else if (reg_wr) begin
            if (int'(reg_addr) < N_ELEM)
                cfg_q[reg_addr[IDX_W-1:0]] <= cell_cfg_t'(reg_wdata[CFG_W-1:0]);
            else if (int'(reg_addr) == A_CLKEN)
                clk_en_q <= reg_wdata[0];
            else if (int'(reg_addr) == A_SWDIN)
                sw_din_q <= reg_wdata[N_ELEM-1:0];
            else if (int'(reg_addr) == A_IRQ)
                irq_src_q <= reg_wdata[SRC_W-1:0];
            else if (int'(reg_addr) == A_CONV)
                conv_src_q <= reg_wdata[SRC_W-1:0];
        end
    end

    // Register read multiplexer, unused bits read zero.
    always_comb begin
        reg_rdata = '0;
        if (int'(reg_addr) < N_ELEM)
            reg_rdata[CFG_W-1:0] = cfg_q[reg_addr[IDX_W-1:0]];
        else if (int'(reg_addr) == A_CLKEN)
            reg_rdata[0] = clk_en_q;
        else if (int'(reg_addr) == A_SWDIN)
            reg_rdata[N_ELEM-1:0] = sw_din_q;
        else if (int'(reg_addr) == A_DOUT)
            reg_rdata[N_ELEM-1:0] = cell_y;
        else if (int'(reg_addr) == A_IRQ)
            reg_rdata[SRC_W-1:0] = irq_src_q;
        else if (int'(reg_addr) == A_CONV)
            reg_rdata[SRC_W-1:0] = conv_src_q;
    end

    // Odd neighbourhood is the same for every cell.
    for (genvar j = 0; j < N_SEL; j++) begin : g_odd
        assign fb_odd[j] = ff_q[2*j+1];
    end

    // Cells, each with its even neighbourhood; cell 0 takes the chain link.
    for (genvar k = 0; k < N_ELEM; k++) begin : g_cell
        logic [N_SEL-1:0] fb_even;
        assign fb_even[0] = (k == 0) ? link_in : ff_q[0];
        for (genvar j = 1; j < N_SEL; j++) begin : g_even
            assign fb_even[j] = ff_q[2*j];
        end
        lut_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .clk_en  (clk_en_q),
            .cfg     (cfg_q[k]),
            .pin     (pin_in[k]),
            .sw_bit  (sw_din_q[k]),
            .fb_even (fb_even),
            .fb_odd  (fb_odd),
            .ff_q    (ff_q[k]),
            .y       (cell_y[k])
        );
    end

    rise_strobe #(.W(N_ELEM), .IDX_W(IDX_W)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig    (cell_y),
        .idx    (irq_src_q[IDX_W-1:0]),
        .en     (irq_src_q[IDX_W]),
        .strobe (irq_pulse)
    );

    rise_strobe #(.W(N_ELEM), .IDX_W(IDX_W)) u_conv (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig    (cell_y),
        .idx    (conv_src_q[IDX_W-1:0]),
        .en     (conv_src_q[IDX_W]),
        .strobe (conv_pulse)
    );

    assign pin_out  = cell_y;
    assign link_out = cell_y[N_ELEM-1];
endmodule

// File: rtl/lut_bank_checker.sv
// Module: property checker for lut_logic_bank, attached by bind.
// Assumes it sees the bank's ports plus the clock enable and flip-flop vector.
module lut_bank_checker
    import lut_bank_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [N_ELEM-1:0] pin_out,
    input logic              irq_pulse,
    input logic              conv_pulse,
    input logic              clk_en,
    input logic [N_ELEM-1:0] ff_q
);
    assert_irq_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    assert_conv_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        conv_pulse |=> !conv_pulse);

    assert_ff_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(ff_q));

    assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-1:CFG_W] == '0);

    assert_dout_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(reg_addr) == A_DOUT) |-> (reg_rdata[N_ELEM-1:0] == pin_out));
endmodule

bind lut_logic_bank lut_bank_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .pin_out    (pin_out),
    .irq_pulse  (irq_pulse),
    .conv_pulse (conv_pulse),
    .clk_en     (clk_en_q),
    .ff_q       (ff_q)
);

// File: tb/test_lut_logic_bank.sv
// Bench: scoreboard. Driver tasks push expected items at a falling edge; a
// monitor pops and compares them 2 ns later, away from the rising edge.
module test_lut_logic_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out;
    logic        link_in = 1'b0;
    logic        link_out;
    logic        irq_pulse;
    logic        conv_pulse;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    typedef enum int {K_PINS, K_RDATA, K_IRQ, K_CONV, K_LINK} kind_t;
    typedef struct {
        kind_t       kind;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #10 clk = ~clk;

    lut_logic_bank i_lut_logic_bank (
        .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
        .pin_in, .pin_out, .link_in, .link_out, .irq_pulse, .conv_pulse
    );

    // Monitor: compare every queued expectation against the ports.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    K_PINS:  act = {24'h0, pin_out};
                    K_RDATA: act = reg_rdata;
                    K_IRQ:   act = {31'h0, irq_pulse};
                    K_CONV:  act = {31'h0, conv_pulse};
                    default: act = {31'h0, link_out};
                endcase
                n_run++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic expect_val(kind_t k, logic [31:0] e, string tag);
        item_t it;
        it.kind = k; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_expect(logic [3:0] a, logic [31:0] e, string tag);
        @(negedge clk);
        reg_addr = a;
        expect_val(K_RDATA, e, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [3:0] tt;
        logic [31:0] cw;
        do_reset();

        // R1: reset state
        @(negedge clk);
        expect_val(K_PINS, 32'h0, "R1 pin_out");
        expect_val(K_IRQ, 32'h0, "R1 irq");
        expect_val(K_CONV, 32'h0, "R1 conv");
        rd_expect(4'd0, 32'h0, "R1 cfg0");
        rd_expect(4'd8, 32'h0, "R1 clken");
        rd_expect(4'd11, 32'h0, "R1 irq src");

        // R2/R3/R4: truth table sweep on cell 0, A = pin, B = software bit
        for (int t = 0; t < 16; t++) begin
            tt = 4'(t);
            wr(4'd0, 32'h20 | (32'(t) << 1));
            for (int ab = 0; ab < 4; ab++) begin
                wr(4'd9, 32'(ab & 1));
                @(negedge clk);
                pin_in[0] = ab[1];
                @(negedge clk);
                expect_val(K_PINS, {31'h0, tt[ab]} & 32'h1 | 32'(pin_out & 8'hFE),
                           "R2 R3 R4 table/pin/swbit");
            end
        end

        // R7: load all flip-flops with a pin pattern, each cell passes A
        pin_in = 8'h9E;
        wr(4'd8, 32'h1);
        for (int k = 0; k < 8; k++) wr(4'(k), 32'h39);
        @(negedge clk);
        expect_val(K_PINS, 32'h9E, "R7 registered load");
        wr(4'd8, 32'h0);
        @(negedge clk);
        pin_in = 8'h00;
        @(negedge clk);
        expect_val(K_PINS, 32'h9E, "R7 hold with enable clear");
        expect_val(K_LINK, 32'h1, "R10 link_out");

        // R5: cell 0 even mux, A from feedback, table passes A
        link_in = 1'b1;
        wr(4'd0, (32'd0 << 9) | 32'h18);
        expect_val(K_PINS, 32'h9F, "R5 code0 link_in=1");
        @(negedge clk);
        link_in = 1'b0;
        @(negedge clk);
        expect_val(K_PINS, 32'h9E, "R5 code0 link_in=0");
        wr(4'd0, (32'd1 << 9) | 32'h18);
        expect_val(K_PINS, 32'h9F, "R5 code1 cell2");
        wr(4'd0, (32'd2 << 9) | 32'h18);
        expect_val(K_PINS, 32'h9F, "R5 code2 cell4");
        wr(4'd0, (32'd3 << 9) | 32'h18);
        expect_val(K_PINS, 32'h9E, "R5 code3 cell6");

        // R6: cell 5 odd mux, B from feedback, table passes B
        wr(4'd5, (32'd0 << 7) | 32'h54);
        expect_val(K_PINS, 32'hBE, "R6 code0 cell1");
        wr(4'd5, (32'd1 << 7) | 32'h54);
        expect_val(K_PINS, 32'hBE, "R6 code1 cell3");
        wr(4'd5, (32'd2 << 7) | 32'h54);
        expect_val(K_PINS, 32'h9E, "R6 code2 cell5");
        wr(4'd5, (32'd3 << 7) | 32'h54);
        expect_val(K_PINS, 32'hBE, "R6 code3 cell7");

        // R9: live output view
        rd_expect(4'd10, 32'hBE, "R9 dout");

        // R7: enable takes effect one edge after the write commits
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'd8; reg_wdata = 32'h1;
        @(negedge clk);
        reg_wr = 1'b0;
        expect_val(K_PINS, {24'h0, pin_out | 8'h08} & 32'h08 | 32'(pin_out & 8'hF7),
                   "R7 hold on enable edge");
        @(negedge clk);
        cw = {24'h0, pin_out};
        expect_val(K_PINS, cw & 32'hF7, "R7 load after enable");

        // R8: reserved bits and unmapped address
        wr(4'd2, 32'hFFFF_FFFF);
        rd_expect(4'd2, 32'h7FF, "R8 cfg readback");
        rd_expect(4'd13, 32'h0, "R8 unmapped");

        // R11: both strobes on the same cell
        do_reset();
        pin_in = 8'h00;
        wr(4'd2, 32'h38);
        wr(4'd11, 32'hA);
        wr(4'd12, 32'hA);
        @(negedge clk);
        pin_in[2] = 1'b1;
        expect_val(K_IRQ, 32'h0, "R11 irq before edge");
        @(negedge clk);
        expect_val(K_IRQ, 32'h1, "R11 irq strobe");
        expect_val(K_CONV, 32'h1, "R11 conv strobe same cycle");
        @(negedge clk);
        expect_val(K_IRQ, 32'h0, "R11 irq one cycle");
        expect_val(K_CONV, 32'h0, "R11 conv one cycle");
        pin_in[2] = 1'b0;
        @(negedge clk);
        expect_val(K_IRQ, 32'h0, "R11 no strobe on fall");
        expect_val(K_CONV, 32'h0, "R11 no conv on fall");
        wr(4'd11, 32'h2);
        @(negedge clk);
        pin_in[2] = 1'b1;
        @(negedge clk);
        expect_val(K_IRQ, 32'h0, "R11 disabled source");
        expect_val(K_CONV, 32'h1, "R11 enabled source");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule